// File: doc/BRIEF.md
# Transfer Descriptor Result Evaluator

This block closes out the processing of one transfer descriptor in a host-side bus scheduler. The scheduler presents the descriptor's 32-bit control word and 32-bit token word together with the outcome the device side reported. The block then returns three things. The first is the control word to write back to memory. The second is a two-bit interrupt-cause mask. The third is a result code that tells the list walker whether to move the queue on to the next descriptor, leave the current descriptor in place, abort the rest of the frame, or wait for a pending asynchronous reply.

The token is split into its packet identifier, device address, endpoint and maximum transfer length, and these fields are returned beside the verdict. The block runs a two-bit error countdown on repeated missing replies. It clamps IN data that overruns the maximum length and flags it as babble. It treats a NAK on a SETUP packet as a missing reply, and it holds the queue when a short IN packet arrives with short-packet detection enabled. Two host error flags report a bad packet identifier and a descriptor retired by the error countdown.

The evaluation is combinational. A one-cycle `start` strobe latches the verdict into an output register, and `done` pulses in the following cycle. The outputs keep their values until the next strobe.

Top module: `td_result_eval`

## Requirements
- R1: The token is decoded as packet identifier = bits 7:0, device address = bits 14:8 and endpoint = bits 18:15. The maximum length is the 11-bit value (bits 31:21 + 1) modulo 2048, so an all-ones field gives a maximum of 0.
- R2: Cause bit 0 equals the interrupt-on-complete bit (control bit 24) for every descriptor. A descriptor whose active bit (bit 23) is clear yields result 1 (leave) with the control word unchanged and no error flags.
- R3: For an active descriptor whose identifier is none of SETUP 0x2D, IN 0x69 or OUT 0xE1, `proc_err` is raised, the result is 2 (abort) and the control word is unchanged, whatever the outcome.
- R4: On outcome 0 (success), the length used is `rx_count` for IN and the maximum length for SETUP or OUT. Bits 10:0 receive (length − 1) modulo 2048, bits 23 (active) and 19 (NAK) are cleared, and the result is 0 (advance).
- R5: An IN success with short-packet detect (bit 29) set and a length below the maximum sets cause bit 1 and yields result 1 (leave).
- R6: An IN success with `rx_count` above the maximum sets babble (bit 20) and stalled (bit 22), clears active, leaves bits 10:0 untouched and yields result 2 (abort).
- R7: Outcome 3 (no response), and the undefined outcomes 5 to 7, set timeout (bit 18). A nonzero error count (bits 28:27) is decremented. If the decrement reaches zero, active is cleared and `usb_err` is raised. A count of zero stays zero. The result is 1 (leave).
- R8: Outcome 1 (NAK) sets bit 19 and yields result 1. On a SETUP identifier, the R7 timeout handling is applied as well.
- R9: Outcome 2 (STALL) sets stalled (bit 22), clears active and yields result 1.
- R10: Outcome 4 (pending) yields result 3 with the control word unchanged and no error flags.
- R11: When isochronous-select (bit 25) is set, active is cleared for every non-pending outcome, including NAK.
- R12: After reset all outputs are zero. A `start` in one cycle gives `done` high in the next cycle only, with outputs reflecting the inputs sampled at that edge, held until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Evaluate the presented descriptor this cycle |
| ctrl_in | input | 32 | Descriptor control word |
| token_in | input | 32 | Descriptor token word |
| outcome | input | 3 | Device outcome: 0 success, 1 NAK, 2 STALL, 3 no response, 4 pending |
| rx_count | input | LEN_W+1 | Bytes the device returned (IN success only) |
| done | output | 1 | One-cycle pulse, outputs valid |
| ctrl_out | output | 32 | Updated control word |
| int_cause | output | 2 | Bit 0 completion, bit 1 short packet |
| result | output | 2 | 0 advance, 1 leave, 2 abort, 3 pending |
| proc_err | output | 1 | Invalid packet identifier |
| usb_err | output | 1 | Descriptor retired by error countdown |
| pid | output | 8 | Decoded packet identifier |
| dev_addr | output | 7 | Decoded device address |
| endpoint | output | 4 | Decoded endpoint |
| max_len | output | LEN_W | Decoded maximum length |

## Verification
The assertions assume that the inputs are stable across the cycle in which `start` is high, so that every registered field can be related to `$past` of the inputs. They also assume that `rx_count` only matters for an IN success. The stimulus changes inputs only at the falling clock edge and drops `start` after one cycle. It selects identifiers mostly from the three valid codes, with some arbitrary bytes, and it uses small maximum lengths so that short, exact and overrun counts all occur. Undefined outcome codes are driven on purpose to exercise their mapping to no response.

// File: rtl/td_eval_pkg.sv
package td_eval_pkg;

  // control word bit positions
  localparam int CB_SPD    = 29;
  localparam int CB_ERR_HI = 28;
  localparam int CB_ERR_LO = 27;
  localparam int CB_ISO    = 25;
  localparam int CB_IOC    = 24;
  localparam int CB_ACT    = 23;
  localparam int CB_STL    = 22;
  localparam int CB_BAB    = 20;
  localparam int CB_NAK    = 19;
  localparam int CB_TMO    = 18;

  // token layout
  localparam int TK_ADDR_LSB = 8;
  localparam int TK_EP_LSB   = 15;
  localparam int TK_LEN_LSB  = 21;

  // packet identifiers, packed so a generate loop can walk them
  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_OUT   = 8'hE1;
  localparam int         NUM_PIDS  = 3;
  localparam logic [8*NUM_PIDS-1:0] PID_LIST = {PID_OUT, PID_IN, PID_SETUP};

  // device outcome codes
  localparam logic [2:0] OC_ACK    = 3'd0;
  localparam logic [2:0] OC_NAK    = 3'd1;
  localparam logic [2:0] OC_STALL  = 3'd2;
  localparam logic [2:0] OC_NORESP = 3'd3;
  localparam logic [2:0] OC_PEND   = 3'd4;

  typedef enum logic [1:0] {
    RES_ADVANCE = 2'd0,
    RES_LEAVE   = 2'd1,
    RES_ABORT   = 2'd2,
    RES_PENDING = 2'd3
  } td_result_e;

endpackage

// File: rtl/td_token_decode.sv
module td_token_decode
  import td_eval_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic [31:0]      token_i,
  output logic [7:0]       pid_o,
  output logic [6:0]       addr_o,
  output logic [3:0]       ep_o,
  output logic [LEN_W-1:0] max_len_o,
  output logic             is_setup_o,
  output logic             is_in_o,
  output logic             pid_ok_o
);

  logic [NUM_PIDS-1:0] hit;
  logic [LEN_W-1:0]    len_field;
  logic                unused_tok;

  assign pid_o     = token_i[7:0];
  assign addr_o    = token_i[TK_ADDR_LSB +: 7];
  assign ep_o      = token_i[TK_EP_LSB +: 4];
  assign len_field = token_i[TK_LEN_LSB +: LEN_W];
  assign unused_tok = ^token_i[TK_LEN_LSB-1:TK_EP_LSB+4];

  // the length field holds (maximum - 1); adding one wraps inside LEN_W
  function automatic logic [LEN_W-1:0] field_to_max(input logic [LEN_W-1:0] f);
    return f + LEN_W'(1);
  endfunction

  assign max_len_o = field_to_max(len_field);

  for (genvar i = 0; i < NUM_PIDS; i++) begin : g_pid_match
    assign hit[i] = (token_i[7:0] == PID_LIST[i*8 +: 8]);
  end

  assign is_setup_o = hit[0];
  assign is_in_o    = hit[1];
  assign pid_ok_o   = |hit;

endmodule

// File: rtl/td_outcome_eval.sv
module td_outcome_eval
  import td_eval_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic [31:0]      ctrl_i,
  input  logic [2:0]       outcome_i,
  input  logic [LEN_W:0]   count_i,
  input  logic [LEN_W-1:0] max_len_i,
  input  logic             is_setup_i,
  input  logic             is_in_i,
  input  logic             pid_ok_i,
  output logic [31:0]      ctrl_o,
  output logic [1:0]       cause_o,
  output td_result_e       res_o,
  output logic             proc_err_o,
  output logic             usb_err_o,
  output logic             ev_badpid_o,
  output logic             ev_babble_o,
  output logic             ev_short_o,
  output logic             ev_retire_o
);

  logic             overrun;
  logic [LEN_W-1:0] eff_len;

  // length written back is one less than the bytes moved, modulo the field
  function automatic logic [LEN_W-1:0] len_code(input logic [LEN_W-1:0] n);
    return n - LEN_W'(1);
  endfunction

  // error countdown: returns {retired, new count}
  function automatic logic [2:0] err_step(input logic [1:0] cnt);
    logic [1:0] nxt;
    nxt = (cnt == 2'd0) ? 2'd0 : cnt - 2'd1;
    return {(cnt == 2'd1), nxt};
  endfunction

  always_comb begin
    if (is_in_i) begin
      overrun = (count_i > {1'b0, max_len_i});
      eff_len = overrun ? max_len_i : count_i[LEN_W-1:0];
    end else begin
      overrun = 1'b0;
      eff_len = max_len_i;
    end
  end

  always_comb begin
    logic       do_timeout;
    logic [2:0] step;

    ctrl_o      = ctrl_i;
    cause_o     = {1'b0, ctrl_i[CB_IOC]};
    res_o       = RES_LEAVE;
    proc_err_o  = 1'b0;
    usb_err_o   = 1'b0;
    ev_badpid_o = 1'b0;
    ev_babble_o = 1'b0;
    ev_short_o  = 1'b0;
    ev_retire_o = 1'b0;
    do_timeout  = 1'b0;
    step        = '0;

    if (!ctrl_i[CB_ACT]) begin
      res_o = RES_LEAVE;
    end else if (!pid_ok_i) begin
      ev_badpid_o = 1'b1;
      proc_err_o  = 1'b1;
      res_o       = RES_ABORT;
    end else if (outcome_i == OC_PEND) begin
      res_o = RES_PENDING;
    end else begin
      if (ctrl_i[CB_ISO]) begin
        ctrl_o[CB_ACT] = 1'b0;
      end
      unique case (outcome_i)
        OC_ACK: begin
          if (overrun) begin
            ev_babble_o    = 1'b1;
            ctrl_o[CB_BAB] = 1'b1;
            ctrl_o[CB_STL] = 1'b1;
            ctrl_o[CB_ACT] = 1'b0;
            res_o          = RES_ABORT;
          end else begin
            ctrl_o[LEN_W-1:0] = len_code(eff_len);
            ctrl_o[CB_ACT]    = 1'b0;
            ctrl_o[CB_NAK]    = 1'b0;
            if (is_in_i && ctrl_i[CB_SPD] && (eff_len < max_len_i)) begin
              ev_short_o = 1'b1;
              cause_o[1] = 1'b1;
              res_o      = RES_LEAVE;
            end else begin
              res_o = RES_ADVANCE;
            end
          end
        end
        OC_NAK: begin
          ctrl_o[CB_NAK] = 1'b1;
          do_timeout     = is_setup_i;
        end
        OC_STALL: begin
          ctrl_o[CB_STL] = 1'b1;
          ctrl_o[CB_ACT] = 1'b0;
        end
        default: begin
          do_timeout = 1'b1;
        end
      endcase

      if (do_timeout) begin
        step = err_step(ctrl_i[CB_ERR_HI:CB_ERR_LO]);
        ctrl_o[CB_TMO]               = 1'b1;
        ctrl_o[CB_ERR_HI:CB_ERR_LO]  = step[1:0];
        if (step[2]) begin
          ev_retire_o    = 1'b1;
          ctrl_o[CB_ACT] = 1'b0;
          usb_err_o      = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/td_result_reg.sv
module td_result_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        q_o <= d_i;
      end
    end
  end

endmodule

// File: rtl/td_result_eval.sv
module td_result_eval
  import td_eval_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      ctrl_in,
  input  logic [31:0]      token_in,
  input  logic [2:0]       outcome,
  input  logic [LEN_W:0]   rx_count,
  output logic             done,
  output logic [31:0]      ctrl_out,
  output logic [1:0]       int_cause,
  output logic [1:0]       result,
  output logic             proc_err,
  output logic             usb_err,
  output logic [7:0]       pid,
  output logic [6:0]       dev_addr,
  output logic [3:0]       endpoint,
  output logic [LEN_W-1:0] max_len
);

  localparam int PACK_W = 32 + 2 + 2 + 1 + 1 + 8 + 7 + 4 + LEN_W;

  logic [7:0]       dec_pid;
  logic [6:0]       dec_addr;
  logic [3:0]       dec_ep;
  logic [LEN_W-1:0] dec_max;
  logic             dec_setup;
  logic             dec_in;
  logic             dec_ok;

  logic [31:0]      nx_ctrl;
  logic [1:0]       nx_cause;
  td_result_e       nx_res;
  logic             nx_perr;
  logic             nx_uerr;

  // internal events, brought out for the checker
  logic             ev_badpid;
  logic             ev_babble;
  logic             ev_short;
  logic             ev_retire;

  logic [PACK_W-1:0] pack_d;
  logic [PACK_W-1:0] pack_q;

  td_token_decode #(.LEN_W(LEN_W)) u_dec (
    .token_i    (token_in),
    .pid_o      (dec_pid),
    .addr_o     (dec_addr),
    .ep_o       (dec_ep),
    .max_len_o  (dec_max),
    .is_setup_o (dec_setup),
    .is_in_o    (dec_in),
    .pid_ok_o   (dec_ok)
  );

  td_outcome_eval #(.LEN_W(LEN_W)) u_eval (
    .ctrl_i      (ctrl_in),
    .outcome_i   (outcome),
    .count_i     (rx_count),
    .max_len_i   (dec_max),
    .is_setup_i  (dec_setup),
    .is_in_i     (dec_in),
    .pid_ok_i    (dec_ok),
    .ctrl_o      (nx_ctrl),
    .cause_o     (nx_cause),
    .res_o       (nx_res),
    .proc_err_o  (nx_perr),
    .usb_err_o   (nx_uerr),
    .ev_badpid_o (ev_badpid),
    .ev_babble_o (ev_babble),
    .ev_short_o  (ev_short),
    .ev_retire_o (ev_retire)
  );

  assign pack_d = {nx_ctrl, nx_cause, nx_res, nx_perr, nx_uerr,
                   dec_pid, dec_addr, dec_ep, dec_max};

  td_result_reg #(.DATA_W(PACK_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (start),
    .d_i     (pack_d),
    .valid_o (done),
    .q_o     (pack_q)
  );

  assign {ctrl_out, int_cause, result, proc_err, usb_err,
          pid, dev_addr, endpoint, max_len} = pack_q;

endmodule

// File: rtl/td_result_eval_chk.sv
module td_result_eval_chk #(
  parameter int LEN_W = 11
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] ctrl_in,
  input logic        done,
  input logic [31:0] ctrl_out,
  input logic [1:0]  int_cause,
  input logic [1:0]  result,
  input logic        proc_err,
  input logic        usb_err,
  input logic        ev_babble,
  input logic        ev_short,
  input logic        ev_retire
);

  // R12: done is exactly the start of the previous cycle
  a_r12_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r12_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));

  // R2: completion cause tracks the interrupt-on-complete bit
  a_r2_ioc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> int_cause[0] == $past(ctrl_in[24]));

  // R3: a bad identifier aborts without touching the word
  a_r3_badpid_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (done && proc_err) |-> (result == 2'd2 && ctrl_out == $past(ctrl_in)));

  // R10: pending leaves the word untouched
  a_r10_pending_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'd3) |-> (ctrl_out == $past(ctrl_in) && !usb_err && !proc_err));

  // R4: an advance always retires the descriptor and clears NAK
  a_r4_advance_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'd0) |-> (!ctrl_out[23] && !ctrl_out[19]));

  // R6: an overrun yields abort with babble and stalled
  a_r6_babble_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ev_babble) |=> (result == 2'd2 && ctrl_out[20] && ctrl_out[22] && !ctrl_out[23]));

  // R5: a short IN holds the queue and raises cause bit 1
  a_r5_short_leave: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ev_short) |=> (result == 2'd1 && int_cause[1]));

  // R7: retirement by countdown raises usb_err with a drained count
  a_r7_retire_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ev_retire) |=> (usb_err && ctrl_out[18] && ctrl_out[28:27] == 2'd0 && !ctrl_out[23]));
  a_r7_usberr_only_on_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (done && usb_err) |-> $past(ev_retire));

endmodule

bind td_result_eval td_result_eval_chk #(.LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .ctrl_in   (ctrl_in),
  .done      (done),
  .ctrl_out  (ctrl_out),
  .int_cause (int_cause),
  .result    (result),
  .proc_err  (proc_err),
  .usb_err   (usb_err),
  .ev_babble (ev_babble),
  .ev_short  (ev_short),
  .ev_retire (ev_retire)
);

// File: tb/td_result_eval_bench.sv
module td_result_eval_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 11;
  localparam int WATCHDOG   = 20000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [31:0]      ctrl_in = '0;
  logic [31:0]      token_in = '0;
  logic [2:0]       outcome = '0;
  logic [LEN_W:0]   rx_count = '0;
  logic             done;
  logic [31:0]      ctrl_out;
  logic [1:0]       int_cause;
  logic [1:0]       result;
  logic             proc_err;
  logic             usb_err;
  logic [7:0]       pid;
  logic [6:0]       dev_addr;
  logic [3:0]       endpoint;
  logic [LEN_W-1:0] max_len;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cycles   = 0;
  bit    finished = 0;
  string drv_tag  = "R12 reset";

  // expected state
  bit          e_done = 0;
  logic [31:0] e_ctrl = '0;
  int          e_cause = 0, e_res = 0, e_pe = 0, e_ue = 0;
  int          e_pid = 0, e_addr = 0, e_ep = 0, e_max = 0;
  string       e_tag = "R12 reset";

  td_result_eval #(.LEN_W(LEN_W)) u_td_result_eval (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_in(ctrl_in),
    .token_in(token_in), .outcome(outcome), .rx_count(rx_count),
    .done(done), .ctrl_out(ctrl_out), .int_cause(int_cause),
    .result(result), .proc_err(proc_err), .usb_err(usb_err),
    .pid(pid), .dev_addr(dev_addr), .endpoint(endpoint), .max_len(max_len)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference of the requirements
  function automatic void ref_eval(input logic [31:0] c_in, input logic [31:0] tk,
                                   input int oc, input int cnt,
                                   output logic [31:0] c_out, output int cause,
                                   output int res, output int pe, output int ue);
    int maxl, id, len, err;
    bit is_in, is_setup;
    c_out = c_in; cause = c_in[24] ? 1 : 0; res = 1; pe = 0; ue = 0;
    maxl = ((tk >> 21) + 1) % 2048;
    id   = tk % 256;
    if (!c_in[23]) return;
    if (id != 'h2D && id != 'h69 && id != 'hE1) begin pe = 1; res = 2; return; end
    if (oc == 4) begin res = 3; return; end
    is_in = (id == 'h69); is_setup = (id == 'h2D);
    if (c_in[25]) c_out[23] = 1'b0;
    if (oc == 0) begin
      len = is_in ? cnt : maxl;
      if (len > maxl) begin
        c_out[20] = 1'b1; c_out[22] = 1'b1; c_out[23] = 1'b0; res = 2; return;
      end
      c_out[10:0] = 11'((len + 2047) % 2048);
      c_out[23] = 1'b0; c_out[19] = 1'b0;
      if (is_in && c_out[29] && len < maxl) begin cause += 2; res = 1; end
      else res = 0;
      return;
    end
    if (oc == 2) begin c_out[22] = 1'b1; c_out[23] = 1'b0; return; end
    if (oc == 1) begin
      c_out[19] = 1'b1;
      if (!is_setup) return;
    end
    c_out[18] = 1'b1;
    err = int'(c_out[28:27]);
    if (err > 0) begin
      err--;
      if (err == 0) begin c_out[23] = 1'b0; ue = 1; end
    end
    c_out[28:27] = 2'(err);
  endfunction

  // model update at the edge
  always @(posedge clk or negedge rst_n) begin
    logic [31:0] c;
    int ca, rs, pe, ue;
    if (!rst_n) begin
      e_done = 0; e_ctrl = '0; e_cause = 0; e_res = 0; e_pe = 0; e_ue = 0;
      e_pid = 0; e_addr = 0; e_ep = 0; e_max = 0;
    end else begin
      e_done = start;
      if (start) begin
        ref_eval(ctrl_in, token_in, int'(outcome), int'(rx_count), c, ca, rs, pe, ue);
        e_ctrl = c; e_cause = ca; e_res = rs; e_pe = pe; e_ue = ue;
        e_pid  = int'(token_in[7:0]);
        e_addr = int'(token_in[14:8]);
        e_ep   = int'(token_in[18:15]);
        e_max  = ((token_in >> 21) + 1) % 2048;
        e_tag  = drv_tag;
      end else begin
        e_tag = {drv_tag, " / R12 hold"};
      end
    end
  end

  // compare once per cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_checks++;
      if (done !== e_done || ctrl_out !== e_ctrl || int'(int_cause) != e_cause ||
          int'(result) != e_res || int'(proc_err) != e_pe || int'(usb_err) != e_ue ||
          int'(pid) != e_pid || int'(dev_addr) != e_addr || int'(endpoint) != e_ep ||
          int'(max_len) != e_max) begin
        n_fail++;
        $display("FAIL %s: got done=%0b ctrl=%h cause=%0d res=%0d pe=%0b ue=%0b pid=%h addr=%0d ep=%0d max=%0d ; expected done=%0b ctrl=%h cause=%0d res=%0d pe=%0d ue=%0d pid=%h addr=%0d ep=%0d max=%0d",
                 e_tag, done, ctrl_out, int_cause, result, proc_err, usb_err, pid, dev_addr,
                 endpoint, max_len, e_done, e_ctrl, e_cause, e_res, e_pe, e_ue, e_pid,
                 e_addr, e_ep, e_max);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL R12 watchdog: got %0d cycles, expected under %0d", cycles, WATCHDOG);
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  function automatic logic [31:0] mk_tok(input int id, input int addr, input int ep, input int mlm1);
    return (32'(mlm1) << 21) | (32'(ep % 16) << 15) | (32'(addr % 128) << 8) | 32'(id % 256);
  endfunction

  // control word from named flags
  function automatic logic [31:0] mk_ctrl(input bit act, input bit ioc, input bit spd,
                                          input bit iso, input int err, input bit nak);
    logic [31:0] w;
    w = 32'h0000_0155;
    w[23] = act; w[24] = ioc; w[29] = spd; w[25] = iso; w[28:27] = 2'(err); w[19] = nak;
    return w;
  endfunction

  task automatic apply(input logic [31:0] c, input logic [31:0] tk, input int oc,
                       input int cnt, input string tag);
    @(negedge clk);
    ctrl_in = c; token_in = tk; outcome = 3'(oc); rx_count = 12'(cnt);
    drv_tag = tag; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state at the ports
    n_checks++;
    if (done !== 1'b0 || ctrl_out !== '0 || result !== 2'd0 || int_cause !== 2'd0 ||
        proc_err !== 1'b0 || usb_err !== 1'b0 || max_len !== '0) begin
      n_fail++;
      $display("FAIL R12 reset: got done=%0b ctrl=%h res=%0d ; expected 0 0 0", done, ctrl_out, result);
    end
    rst_n = 1'b1;
    @(negedge clk);

    apply(mk_ctrl(0,1,0,0,3,0), mk_tok('h69, 5, 2, 7), 0, 3, "R2 inactive with completion bit");
    apply(mk_ctrl(1,0,0,0,3,0), mk_tok('h55, 1, 1, 7), 0, 3, "R3 bad identifier");
    apply(mk_ctrl(1,0,0,0,3,0), mk_tok('h55, 1, 1, 7), 4, 3, "R3 bad identifier with pending");
    apply(mk_ctrl(1,1,0,0,3,0), mk_tok('hE1, 9, 3, 7), 0, 3, "R4 OUT success uses maximum");
    apply(mk_ctrl(1,0,0,0,3,0), mk_tok('h2D, 0, 0, 7), 0, 0, "R4 SETUP success");
    apply(mk_ctrl(1,0,1,0,3,0), mk_tok('h69, 4, 1, 7), 0, 8, "R4 IN exact length");
    apply(mk_ctrl(1,0,0,0,3,1), mk_tok('h69, 4, 1, 7), 0, 0, "R4 IN zero length clears NAK");
    apply(mk_ctrl(1,1,1,0,3,0), mk_tok('h69, 4, 1, 7), 0, 3, "R5 short IN with detect");
    apply(mk_ctrl(1,0,0,0,3,0), mk_tok('h69, 4, 1, 7), 0, 3, "R5 short IN without detect");
    apply(mk_ctrl(1,0,0,0,3,0), mk_tok('h69, 4, 1, 7), 0, 9, "R6 IN overrun");
    apply(mk_ctrl(1,0,0,0,3,0), mk_tok('h69, 4, 1, 2047), 0, 0, "R1 zero maximum, zero bytes");
    apply(mk_ctrl(1,0,0,0,3,0), mk_tok('h69, 127, 15, 2047), 0, 1, "R1 R6 zero maximum overrun");
    apply(mk_ctrl(1,0,0,0,3,0), mk_tok('hE1, 100, 12, 1023), 3, 0, "R7 countdown 3 to 2");
    apply(mk_ctrl(1,0,0,0,1,0), mk_tok('hE1, 100, 12, 1023), 3, 0, "R7 countdown retires");
    apply(mk_ctrl(1,0,0,0,0,0), mk_tok('hE1, 100, 12, 1023), 3, 0, "R7 zero count stays");
    apply(mk_ctrl(1,0,0,0,2,0), mk_tok('h69, 3, 3, 15), 6, 0, "R7 undefined outcome");
    apply(mk_ctrl(1,0,0,0,1,0), mk_tok('h69, 3, 3, 15), 1, 0, "R8 NAK on IN");
    apply(mk_ctrl(1,0,0,0,1,0), mk_tok('h2D, 3, 3, 15), 1, 0, "R8 NAK on SETUP retires");
    apply(mk_ctrl(1,1,0,0,2,0), mk_tok('hE1, 3, 3, 15), 2, 0, "R9 STALL");
    apply(mk_ctrl(1,1,0,0,2,1), mk_tok('h69, 3, 3, 15), 4, 5, "R10 pending");
    apply(mk_ctrl(1,0,0,1,2,0), mk_tok('h69, 3, 3, 15), 1, 0, "R11 isochronous NAK");
    apply(mk_ctrl(1,0,0,1,2,0), mk_tok('h69, 3, 3, 15), 4, 0, "R11 isochronous pending keeps active");

    for (int i = 0; i < 400; i++) begin
      int sel, id;
      logic [31:0] c;
      sel = int'($urandom % 8);
      id  = (sel < 3) ? 'h69 : (sel < 5) ? 'hE1 : (sel < 7) ? 'h2D : int'($urandom % 256);
      c   = $urandom;
      if ($urandom % 4 != 0) c[23] = 1'b1;
      apply(c, mk_tok(id, int'($urandom), int'($urandom),
                      ($urandom % 16 == 0) ? 2047 : int'($urandom % 16)),
            int'($urandom % 8), int'($urandom % 20), "R1 R11 random mix");
    end

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule